// File: doc/BRIEF.md
# Frame-Based Power-of-Two Gain Control

This block scales a stream of signed I/Q sample pairs by a power of two chosen from a signed shift in the range -7 to +7. A positive shift multiplies the sample, and a negative shift divides it with an arithmetic (floor) shift. The result is clamped to the sample width and delivered one cycle later. While samples flow, the block measures the scaled output. It keeps the largest magnitude seen in the current frame and counts how many samples hit the clamp limits.

A frame-boundary pulse closes the current frame. The peak and clip count are then frozen into a status snapshot. With automatic mode on, the boundary also adjusts the gain: a loud frame reduces it by the attack step. A run of quiet frames raises it by the decay step once a programmable holdoff has passed. With automatic mode off, a manual gain input sets the shift directly.

A one-bit clip indicator and a packed status word make the measured state visible to an outer control loop. The enclosing system keeps the configuration inputs steady from its own register bank.

Top module: `shift_agc`

## Requirements
- R1: The gain is a 4-bit two's complement shift g in -7..+7. The output is floor(x * 2^g) for each of I and Q, using the gain held before the sample's clock edge.
- R2: Scaled values above 2^(DW-1)-1 or below -2^(DW-1) are clamped to those limits. A sample whose I or Q was clamped counts as clipped.
- R3: out_valid equals in_valid delayed by exactly one clock. out_i and out_q carry that sample's scaled result in the same cycle.
- R4: Within a frame the block tracks the maximum of |I| and |Q| over the scaled, clamped outputs. It also counts clipped samples, and this count holds at 2^SAT_W-1 instead of wrapping.
- R5: On a cycle with frame_end high, a valid sample in that same cycle belongs to the closing frame. The frame's peak and count are captured, and the next frame starts from peak 0 and count 0.
- R6: In automatic mode, a closing frame with any clipped sample or with peak > cfg_target lowers the gain by cfg_attack, stopping at -7. The quiet-frame counter then restarts at 0.
- R7: In automatic mode, a closing frame that is not loud counts as quiet. If H = cfg_holdoff quiet frames have already been counted, the gain rises by cfg_decay, stopping at +7, and the counter restarts. The gain therefore rises on the (H+1)th consecutive quiet frame.
- R8: In automatic mode the gain changes only in the clock that follows a frame_end cycle.
- R9: With cfg_auto_en low, the gain takes cfg_manual_gain one clock later, and code 4'b1000 is read as -7. The quiet-frame counter is held at 0, so re-enabling starts from the manual gain with a fresh holdoff.
- R10: sat_flag goes high after a frame closes with at least one clipped sample and stays high until the next frame closes without clipping.
- R11: status_word bits [DW-1:0] hold the captured peak, [DW+SAT_W-1:DW] the captured clip count, [DW+SAT_W+3:DW+SAT_W] the gain, and the top bit cfg_auto_en delayed by one clock.
- R12: While rst_n is low, out_valid, out_i, out_q, sat_flag and status_word are all 0, and the gain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Signed in-phase sample |
| in_q | input | DW | Signed quadrature sample |
| frame_end | input | 1 | Frame-boundary pulse, closes the frame on this cycle |
| cfg_auto_en | input | 1 | Automatic gain mode enable |
| cfg_target | input | DW | Peak level above which a frame is loud (unsigned) |
| cfg_attack | input | 3 | Gain decrement for a loud frame |
| cfg_decay | input | 3 | Gain increment after holdoff |
| cfg_holdoff | input | HOLD_W | Quiet frames required before a raise |
| cfg_manual_gain | input | 4 | Signed gain used when automatic mode is off |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | Scaled in-phase sample |
| out_q | output | DW | Scaled quadrature sample |
| sat_flag | output | 1 | Last closed frame had clipping |
| status_word | output | DW+SAT_W+5 | Packed enable, gain, clip count, peak |

## Verification
Several properties are checked on every clock:
- the one-cycle valid latency;
- the gain never taking the unused code -8;
- the gain holding between boundaries in automatic mode;
- the direction of every attack and decay step;
- the manual gain following its input;
- the accumulators clearing after a boundary;
- the clip indicator matching the captured count.

Some behaviour only the bench can show, by comparing against its own model:
- the exact scaled and clamped values, including floor rounding of negative samples;
- a sample on the boundary cycle being counted in the closing frame;
- the exact quiet-frame count before a raise, and its restart on re-enable;
- the status packing under random traffic and configuration changes.

// File: rtl/shift_agc_pkg.sv
package shift_agc_pkg;
  localparam int GAIN_W = 4;
  localparam int STEP_W = 3;

  typedef logic signed [GAIN_W-1:0] gain_t;

  localparam gain_t GAIN_MAX = 4'sd7;
  localparam gain_t GAIN_MIN = -4'sd7;

  // limit a widened gain sum to the legal -7..+7 range
  function automatic gain_t gain_limit(input logic signed [5:0] v);
    if (v > 6'sd7)       return GAIN_MAX;
    else if (v < -6'sd7) return GAIN_MIN;
    else                 return v[3:0];
  endfunction

  // step the gain up or down; the sign bit is replicated when widening
  function automatic gain_t gain_step(input gain_t g, input logic [STEP_W-1:0] s,
                                      input logic up);
    logic signed [5:0] gw;
    logic signed [5:0] sw;
    gw = {{2{g[GAIN_W-1]}}, g};
    sw = {3'b000, s};
    return gain_limit(up ? (gw + sw) : (gw - sw));
  endfunction

  // manual code 1000 has no positive mirror, read it as -7
  function automatic gain_t gain_sanitize(input gain_t g);
    return (g == 4'sb1000) ? GAIN_MIN : g;
  endfunction
endpackage

// File: rtl/agc_scaler.sv
module agc_scaler
  import shift_agc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  gain_t                gain,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic        [DW-1:0] mag_now,
  output logic                 clip_now
);
  localparam int EW = DW + 8;
  localparam logic signed [EW-1:0] MAXV = {{(EW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {{(EW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic signed [EW-1:0] shift_ext(input logic signed [DW-1:0] x,
                                                     input gain_t g);
    logic signed [EW-1:0] e;
    logic [3:0] ng;
    e = {{(EW-DW){x[DW-1]}}, x};
    if (!g[GAIN_W-1]) begin
      return e <<< g[2:0];
    end
    ng = ~g + 4'd1;
    return e >>> ng[2:0];
  endfunction

  function automatic logic is_clip(input logic signed [EW-1:0] e);
    return (e > MAXV) || (e < MINV);
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [EW-1:0] e);
    if (e > MAXV)      return MAXV[DW-1:0];
    else if (e < MINV) return MINV[DW-1:0];
    else               return e[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] magnitude(input logic signed [DW-1:0] x);
    return x[DW-1] ? (~x + 1'b1) : x;
  endfunction

  logic signed [EW-1:0] wide_i, wide_q;
  logic signed [DW-1:0] sc_i, sc_q;
  logic [DW-1:0] mag_i, mag_q;

  always_comb begin
    wide_i   = shift_ext(in_i, gain);
    wide_q   = shift_ext(in_q, gain);
    sc_i     = clamp(wide_i);
    sc_q     = clamp(wide_q);
    clip_now = is_clip(wide_i) || is_clip(wide_q);
    mag_i    = magnitude(sc_i);
    mag_q    = magnitude(sc_q);
    mag_now  = (mag_i > mag_q) ? mag_i : mag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= sc_i;
        out_q <= sc_q;
      end
    end
  end

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/agc_frame_meter.sv
module agc_frame_meter #(
  parameter int DW    = 16,
  parameter int SAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             frame_end,
  input  logic [DW-1:0]    mag_now,
  input  logic             clip_now,
  output logic [DW-1:0]    peak_incl,
  output logic [SAT_W-1:0] clips_incl,
  output logic [DW-1:0]    snap_peak,
  output logic [SAT_W-1:0] snap_clips,
  output logic             sat_flag
);
  localparam logic [SAT_W-1:0] CNT_TOP = '1;

  logic [DW-1:0]    acc_peak;
  logic [SAT_W-1:0] acc_clips;

  // frame totals including the current cycle's sample, used at the boundary
  always_comb begin
    peak_incl  = acc_peak;
    clips_incl = acc_clips;
    if (in_valid) begin
      if (mag_now > acc_peak) peak_incl = mag_now;
      if (clip_now && acc_clips != CNT_TOP) clips_incl = acc_clips + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_peak   <= '0;
      acc_clips  <= '0;
      snap_peak  <= '0;
      snap_clips <= '0;
      sat_flag   <= 1'b0;
    end else if (frame_end) begin
      snap_peak  <= peak_incl;
      snap_clips <= clips_incl;
      sat_flag   <= (clips_incl != '0);
      acc_peak   <= '0;
      acc_clips  <= '0;
    end else begin
      acc_peak   <= peak_incl;
      acc_clips  <= clips_incl;
    end
  end

  p_frame_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (acc_peak == '0 && acc_clips == '0));
  p_flag_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag == (snap_clips != '0));
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import shift_agc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SAT_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              auto_en,
  input  gain_t             manual_gain,
  input  logic [STEP_W-1:0] attack,
  input  logic [STEP_W-1:0] decay,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic [DW-1:0]     target,
  input  logic [DW-1:0]     frame_peak,
  input  logic [SAT_W-1:0]  frame_clips,
  output gain_t             gain,
  output logic              auto_q
);
  localparam logic [HOLD_W-1:0] QUIET_TOP = '1;

  logic [HOLD_W-1:0] quiet_cnt;
  logic loud;
  logic ev_attack, ev_quiet, ev_decay;

  assign loud      = (frame_clips != '0) || (frame_peak > target);
  assign ev_attack = auto_en && frame_end && loud;
  assign ev_quiet  = auto_en && frame_end && !loud;
  assign ev_decay  = ev_quiet && (quiet_cnt >= holdoff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain      <= '0;
      quiet_cnt <= '0;
      auto_q    <= 1'b0;
    end else begin
      auto_q <= auto_en;
      if (!auto_en) begin
        gain      <= gain_sanitize(manual_gain);
        quiet_cnt <= '0;
      end else if (ev_attack) begin
        gain      <= gain_step(gain, attack, 1'b0);
        quiet_cnt <= '0;
      end else if (ev_decay) begin
        gain      <= gain_step(gain, decay, 1'b1);
        quiet_cnt <= '0;
      end else if (ev_quiet && quiet_cnt != QUIET_TOP) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  p_gain_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gain != 4'sb1000);
  p_hold_midframe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !frame_end) |=> $stable(gain));
  p_attack_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_attack |=> (gain <= $past(gain)));
  p_decay_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decay |=> (gain >= $past(gain)));
  p_manual_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && manual_gain != 4'sb1000) |=> (gain == $past(manual_gain)));
endmodule

// File: rtl/shift_agc.sv
module shift_agc
  import shift_agc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SAT_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [DW-1:0]       in_i,
  input  logic signed [DW-1:0]       in_q,
  input  logic                       frame_end,
  input  logic                       cfg_auto_en,
  input  logic [DW-1:0]              cfg_target,
  input  logic [2:0]                 cfg_attack,
  input  logic [2:0]                 cfg_decay,
  input  logic [HOLD_W-1:0]          cfg_holdoff,
  input  logic [3:0]                 cfg_manual_gain,
  output logic                       out_valid,
  output logic signed [DW-1:0]       out_i,
  output logic signed [DW-1:0]       out_q,
  output logic                       sat_flag,
  output logic [DW+SAT_W+4:0]        status_word
);
  gain_t            gain;
  logic             auto_q;
  logic [DW-1:0]    mag_now;
  logic             clip_now;
  logic [DW-1:0]    peak_incl, snap_peak;
  logic [SAT_W-1:0] clips_incl, snap_clips;

  agc_scaler #(.DW(DW)) u_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain(gain), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .mag_now(mag_now), .clip_now(clip_now)
  );

  agc_frame_meter #(.DW(DW), .SAT_W(SAT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_end(frame_end),
    .mag_now(mag_now), .clip_now(clip_now), .peak_incl(peak_incl),
    .clips_incl(clips_incl), .snap_peak(snap_peak), .snap_clips(snap_clips),
    .sat_flag(sat_flag)
  );

  agc_gain_ctrl #(.DW(DW), .SAT_W(SAT_W), .HOLD_W(HOLD_W)) u_gain (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .auto_en(cfg_auto_en),
    .manual_gain(cfg_manual_gain), .attack(cfg_attack), .decay(cfg_decay),
    .holdoff(cfg_holdoff), .target(cfg_target), .frame_peak(peak_incl),
    .frame_clips(clips_incl), .gain(gain), .auto_q(auto_q)
  );

  // R11 packing: enable | gain | clip count | peak
  assign status_word = {auto_q, gain, snap_clips, snap_peak};
endmodule

// File: tb/shift_agc_bench.sv
`timescale 1ns/1ps
module shift_agc_bench;
  localparam int DW = 16;
  localparam int SAT_W = 8;
  localparam int HOLD_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic frame_end = 1'b0;
  logic cfg_auto_en = 1'b0;
  logic [DW-1:0] cfg_target = '0;
  logic [2:0] cfg_attack = '0, cfg_decay = '0;
  logic [HOLD_W-1:0] cfg_holdoff = '0;
  logic [3:0] cfg_manual_gain = '0;
  logic out_valid;
  logic signed [DW-1:0] out_i, out_q;
  logic sat_flag;
  logic [DW+SAT_W+4:0] status_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  int m_gain = 0, m_quiet = 0, m_peak = 0, m_clips = 0;
  int s_peak = 0, s_clips = 0, s_flag = 0, m_en_q = 0;

  always #5 clk = ~clk;

  shift_agc #(.DW(DW), .SAT_W(SAT_W), .HOLD_W(HOLD_W)) u_shift_agc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .frame_end(frame_end), .cfg_auto_en(cfg_auto_en), .cfg_target(cfg_target),
    .cfg_attack(cfg_attack), .cfg_decay(cfg_decay), .cfg_holdoff(cfg_holdoff),
    .cfg_manual_gain(cfg_manual_gain), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .sat_flag(sat_flag), .status_word(status_word)
  );

  function automatic int ref_scale(int x, int g);
    int v = x;
    if (g >= 0) return x * (1 << g);
    for (int k = 0; k < -g; k++) v = (v < 0) ? -((-v + 1) / 2) : v / 2;
    return v;
  endfunction

  function automatic int ref_clamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dut_gain();
    logic signed [3:0] g;
    g = status_word[DW+SAT_W +: 4];
    return int'(g);
  endfunction

  // one clock of stimulus, model update and output comparison
  task automatic step(bit v, int xi, int xq, bit fe);
    int ei, eq, pk, cc, clip, mag, manual;
    logic [DW+SAT_W+4:0] est;
    @(negedge clk);
    in_valid = v; in_i = xi[DW-1:0]; in_q = xq[DW-1:0]; frame_end = fe;
    ei = ref_scale(int'($signed(in_i)), m_gain);
    eq = ref_scale(int'($signed(in_q)), m_gain);
    clip = (ref_clamp(ei) != ei || ref_clamp(eq) != eq) ? 1 : 0;
    ei = ref_clamp(ei); eq = ref_clamp(eq);
    mag = (iabs(ei) > iabs(eq)) ? iabs(ei) : iabs(eq);
    pk = m_peak; cc = m_clips;
    if (v) begin
      if (mag > pk) pk = mag;
      if (clip != 0 && cc < 255) cc++;
    end
    if (fe) begin
      s_peak = pk; s_clips = cc; s_flag = (cc != 0);
      m_peak = 0; m_clips = 0;
    end else begin
      m_peak = pk; m_clips = cc;
    end
    manual = int'($signed(cfg_manual_gain));
    if (!cfg_auto_en) begin
      m_gain = (manual < -7) ? -7 : manual;
      m_quiet = 0;
    end else if (fe) begin
      if (cc > 0 || pk > int'(cfg_target)) begin
        m_gain = m_gain - int'(cfg_attack);
        if (m_gain < -7) m_gain = -7;
        m_quiet = 0;
      end else if (m_quiet >= int'(cfg_holdoff)) begin
        m_gain = m_gain + int'(cfg_decay);
        if (m_gain > 7) m_gain = 7;
        m_quiet = 0;
      end else if (m_quiet < 15) begin
        m_quiet++;
      end
    end
    m_en_q = cfg_auto_en;
    @(posedge clk); #2;
    chk("R3 out_valid", out_valid, v);
    if (v) begin
      chk("R1/R2 out_i", int'(out_i), ei);
      chk("R1/R2 out_q", int'(out_q), eq);
    end
    est = {m_en_q[0], 4'(m_gain), 8'(s_clips), 16'(s_peak)};
    chk("R11 status_word", int'(status_word), int'(est));
    chk("R10 sat_flag", sat_flag, s_flag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #2;
    // R12 reset state
    chk("R12 out_valid in reset", out_valid, 0);
    chk("R12 status in reset", int'(status_word), 0);
    chk("R12 sat_flag in reset", sat_flag, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9 / R1 manual gain and shift semantics
    cfg_manual_gain = 4'd3;
    step(0, 0, 0, 0);
    chk("R9 manual gain 3", dut_gain(), 3);
    step(1, 100, -100, 0);
    chk("R1 left shift by 3", int'(out_i), 800);
    cfg_manual_gain = 4'b1110;   // -2
    step(0, 0, 0, 0);
    step(1, -5, 5, 0);
    chk("R1 floor right shift", int'(out_i), -2);
    chk("R1 positive right shift", int'(out_q), 1);
    cfg_manual_gain = 4'b1000;
    step(0, 0, 0, 0);
    chk("R9 code 1000 read as -7", dut_gain(), -7);

    // R2 / R4 / R10 clipping frame
    cfg_manual_gain = 4'd7;
    step(0, 0, 0, 0);
    step(1, 1000, 0, 0);
    chk("R2 clamp high", int'(out_i), 32767);
    step(1, 0, -1000, 0);
    chk("R2 clamp low", int'(out_q), -32768);
    step(1, 1, 1, 1);
    chk("R4 clip count", int'(status_word[DW +: SAT_W]), 2);
    chk("R4 peak is 32768", int'(status_word[DW-1:0]), 32768);
    chk("R10 flag after clipped frame", sat_flag, 1);
    step(0, 0, 0, 1);
    chk("R10 flag drops after quiet frame", sat_flag, 0);

    // R5 boundary-cycle sample counts in closing frame
    cfg_manual_gain = 4'd0;
    step(0, 0, 0, 0);
    step(1, 10, -20, 0);
    step(1, 500, 3, 1);
    chk("R5 boundary sample in peak", int'(status_word[DW-1:0]), 500);
    step(0, 0, 0, 1);
    chk("R5 new frame starts empty", int'(status_word[DW-1:0]), 0);

    // R6 / R8 attack
    cfg_target = 16'd100; cfg_attack = 3'd3; cfg_decay = 3'd1; cfg_holdoff = 4'd2;
    cfg_auto_en = 1'b1;
    step(1, 2000, 0, 1);
    chk("R6 attack to -3", dut_gain(), -3);
    step(1, 30000, 0, 0);
    chk("R8 gain held mid-frame", dut_gain(), -3);
    step(0, 0, 0, 1);
    chk("R6 attack to -6", dut_gain(), -6);
    step(1, 32000, 0, 1);
    chk("R6 attack limited at -7", dut_gain(), -7);
    step(1, 32000, 0, 1);
    chk("R6 stays at -7", dut_gain(), -7);

    // R7 decay after holdoff of 2 quiet frames
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R7 no raise before holdoff", dut_gain(), -7);
    step(0, 0, 0, 1);
    chk("R7 raise on third quiet frame", dut_gain(), -6);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R7 second raise", dut_gain(), -5);

    // R9 re-enable restarts holdoff
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    cfg_manual_gain = 4'b1011;  // -5
    cfg_auto_en = 1'b0;
    step(0, 0, 0, 0);
    cfg_auto_en = 1'b1;
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R9 holdoff restarted on re-enable", dut_gain(), -5);
    step(0, 0, 0, 1);
    chk("R9 raise after fresh holdoff", dut_gain(), -4);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int sh, xi, xq;
      if (n % 250 == 0) begin
        cfg_auto_en     = ($urandom_range(0, 3) != 0);
        cfg_target      = 16'($urandom_range(0, 32768));
        cfg_attack      = 3'($urandom_range(0, 7));
        cfg_decay       = 3'($urandom_range(0, 7));
        cfg_holdoff     = 4'($urandom_range(0, 15));
        cfg_manual_gain = 4'($urandom_range(0, 15));
      end
      sh = $urandom_range(0, 15);
      xi = int'($signed(16'($urandom))) >>> sh;
      xq = int'($signed(16'($urandom))) >>> sh;
      step($urandom_range(0, 3) != 0, xi, xq, $urandom_range(0, 15) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule